// File: doc/BRIEF.md
# Serial Peripheral Port with Collision and Multi-Master Fault Protection

This block is a byte-wide serial peripheral port that works either as the clock-driving side (master) or as the clock-following side (slave) of an SPI link. A processor reaches it through a three-register port: control, status and data. Transmission has no holding stage, so a data-register write while the port is idle goes straight into the shift register. In master mode that write also starts a transfer. The data register reads back the byte received by the most recent completed transfer.

Three sticky flags report events: a transfer has completed, a data write was rejected because a transfer was running, and a mode fault was seen. A mode fault means that another device pulled the slave-select pin low while this port was driving the bus as master. On a fault the port drops its master and enable bits by itself and releases every pin driver. This protects the bus when two masters contend. A control bit can turn the slave-select pin into a general output, which the master then uses to select a remote slave; in that setting fault sensing is off.

Master timing is fixed to mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge. The master clock runs at the system clock divided by twice `SCK_HALF`. In slave mode the pins pass through two-flop synchronizers, so the remote clock may be at most one eighth of the system clock.

Top module: `spi_ctrl`

## Requirements
- R1: The port shifts most significant bit first when control bit 2 is 0, and least significant bit first when it is 1. The setting applies to both the sent and the received byte.
- R2: A write to the data register (address 2) while no transfer runs loads the shift register. If control bit 0 (enable) and bit 1 (master) are both 1, the write also starts a transfer. The port then issues exactly 8 SCK pulses with a period of 2*SCK_HALF system clocks, idle low.
- R3: A data write while a transfer runs sets the collision flag (status bit 1) and is discarded. The running transfer completes with the original bytes on both sides.
- R4: Collision detection also works in slave mode, where a transfer is running from the first detected SCK rising edge to the eighth falling edge.
- R5: At the end of a byte, the received value becomes readable at the data address, and the done flag (status bit 0) is set.
- R6: irq is high only when the global input gie is 1, control bit 3 (interrupt enable) is 1, and the done or fault flag is set.
- R7: With control bit 4 at 0 (slave-select as input), a low level on ss_n_i while enable and master are both set causes a mode fault. The fault flag (status bit 2) is set, hardware clears enable and master, sck_oe/mosi_oe/ss_n_oe drop in the same cycle, and the running transfer is aborted without setting the done flag.
- R8: With control bit 4 at 1, slave-select is an output: ss_n_o follows control bit 5, ss_n_oe is high while enable and master are set, and a low ss_n_i never raises the fault flag.
- R9: Flags are cleared only by writing 1 to their status bit (address 1). Writing 0 leaves them unchanged, and a hardware set in the same cycle wins over the clear.
- R10: In slave mode (enable 1, master 0), the port drives miso only while ss_n_i is low. It receives from mosi on synchronized SCK edges and sets its own done flag.
- R11: After reset, control and status read 0, irq is 0 and every output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock driver enable |
| mosi_i | input | 1 | Master-out line in (slave) |
| mosi_o | output | 1 | Master-out line out |
| mosi_oe | output | 1 | Master-out driver enable |
| miso_i | input | 1 | Master-in line in (master) |
| miso_o | output | 1 | Master-in line out (slave) |
| miso_oe | output | 1 | Master-in driver enable |
| ss_n_i | input | 1 | Slave-select in, active low |
| ss_n_o | output | 1 | Slave-select out, active low |
| ss_n_oe | output | 1 | Slave-select driver enable |

## Verification
The bench builds two copies, both with DW=8 and SCK_HALF=4. One acts as master and selects the other as slave, so every transfer exercises master shifting, the slave synchronizers and both bit orders, with mixed-order pairs giving bit-reversed results. Using SCK_HALF=4 gives the master the one-eighth clock ratio that the slave needs. This lets the same link also carry collision writes on either side and a fault injected on the master's slave-select input in the middle of a byte.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int CTRL_W = 6;
  localparam int CB_EN   = 0;
  localparam int CB_MSTR = 1;
  localparam int CB_LSB  = 2;
  localparam int CB_IE   = 3;
  localparam int CB_SSO  = 4;
  localparam int CB_SSV  = 5;

  localparam int SB_DONE = 0;
  localparam int SB_WCOL = 1;
  localparam int SB_MODF = 2;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic sample_p,
  output logic shift_p
);
  localparam int CW = $clog2(2 * HALF);
  localparam logic [CW-1:0] C_RISE = CW'(HALF - 1);
  localparam logic [CW-1:0] C_FALL = CW'(2 * HALF - 1);
  localparam logic [CW-1:0] C_HIGH = CW'(HALF);

  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt = '0;
    if (run) cnt_nxt = (cnt_q == C_FALL) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign sck      = run && (cnt_q >= C_HIGH);
  assign sample_p = run && (cnt_q == C_RISE);
  assign shift_p  = run && (cnt_q == C_FALL);
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         lsb_first,
  input  logic         sample,
  input  logic         in_bit,
  input  logic         shift,
  input  logic         abort,
  output logic         out_bit,
  output logic         last,
  output logic [W-1:0] rx,
  output logic         done
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] C_LAST = CW'(W - 1);

  logic [W-1:0]  sr_q, sr_nxt, rx_q, rx_nxt, shifted;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          samp_q, samp_nxt, done_q;

  assign shifted = lsb_first ? {samp_q, sr_q[W-1:1]} : {sr_q[W-2:0], samp_q};
  assign last    = shift && !abort && (cnt_q == C_LAST);

  always_comb begin
    sr_nxt   = sr_q;
    cnt_nxt  = cnt_q;
    rx_nxt   = rx_q;
    samp_nxt = sample ? in_bit : samp_q;
    if (load)                sr_nxt = load_val;
    else if (shift && !abort) sr_nxt = shifted;
    if (abort)      cnt_nxt = '0;
    else if (shift) cnt_nxt = last ? '0 : cnt_q + 1'b1;
    if (last) rx_nxt = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      rx_q   <= '0;
      samp_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sr_q   <= sr_nxt;
      cnt_q  <= cnt_nxt;
      rx_q   <= rx_nxt;
      samp_q <= samp_nxt;
      done_q <= last;
    end
  end

  assign out_bit = lsb_first ? sr_q[0] : sr_q[W-1];
  assign rx      = rx_q;
  assign done    = done_q;
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_pkg::*;
#(
  parameter int DW       = 8,
  parameter int SCK_HALF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          gie,
  output logic          irq,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          ss_n_i,
  output logic          ss_n_o,
  output logic          ss_n_oe
);
  localparam int PAD_C = DW - CTRL_W;
  localparam int PAD_S = DW - 3;

  logic rst_core_n;
  logic ss_s, mosi_s, sck_s;

  spi_sync #(.W(1), .RST_VAL(1'b0)) u_rsync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_core_n)
  );

  spi_sync #(.W(3), .RST_VAL(3'b100)) u_psync (
    .clk(clk), .rst_n(rst_core_n),
    .d({ss_n_i, mosi_i, sck_i}), .q({ss_s, mosi_s, sck_s})
  );

  logic [CTRL_W-1:0] ctrl_q, ctrl_nxt;
  logic done_q, done_nxt, wcol_q, wcol_nxt, modf_q, modf_nxt;
  logic busy_q, busy_nxt, sck_p_q;

  logic wr_ctrl, wr_stat, wr_data;
  logic en, mstr, sel, slv_act, fault;
  logic s_rise, s_fall, m_run, m_sck, m_samp, m_shift;
  logic start, load, sample, shift, abort, in_bit;
  logic out_bit, last, xfer_done;
  logic [DW-1:0] rx;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_data = bus_wr && (bus_addr == A_DATA);

  assign en      = ctrl_q[CB_EN];
  assign mstr    = ctrl_q[CB_MSTR];
  assign sel     = !ss_s;
  assign slv_act = en && !mstr && sel;
  assign fault   = en && mstr && !ctrl_q[CB_SSO] && !ss_s;

  assign s_rise  = slv_act && sck_s && !sck_p_q;
  assign s_fall  = slv_act && !sck_s && sck_p_q;
  assign m_run   = busy_q && en && mstr;

  spi_sck_gen #(.HALF(SCK_HALF)) u_sck (
    .clk(clk), .rst_n(rst_core_n), .run(m_run),
    .sck(m_sck), .sample_p(m_samp), .shift_p(m_shift)
  );

  assign start  = wr_data && !busy_q && en && mstr && !fault;
  assign load   = wr_data && !busy_q;
  assign sample = mstr ? m_samp : s_rise;
  assign shift  = mstr ? m_shift : (s_fall && busy_q);
  assign abort  = fault || !en || (!mstr && !sel);
  assign in_bit = mstr ? miso_i : mosi_s;

  spi_shift #(.W(DW)) u_shift (
    .clk(clk), .rst_n(rst_core_n),
    .load(load), .load_val(bus_wdata), .lsb_first(ctrl_q[CB_LSB]),
    .sample(sample), .in_bit(in_bit), .shift(shift), .abort(abort),
    .out_bit(out_bit), .last(last), .rx(rx), .done(xfer_done)
  );

  always_comb begin
    ctrl_nxt = wr_ctrl ? bus_wdata[CTRL_W-1:0] : ctrl_q;
    if (fault) begin
      ctrl_nxt[CB_EN]   = 1'b0;
      ctrl_nxt[CB_MSTR] = 1'b0;
    end
    busy_nxt = busy_q;
    if (abort || last)      busy_nxt = 1'b0;
    else if (start || s_rise) busy_nxt = 1'b1;
    done_nxt = xfer_done || (done_q && !(wr_stat && bus_wdata[SB_DONE]));
    wcol_nxt = (wr_data && busy_q) || (wcol_q && !(wr_stat && bus_wdata[SB_WCOL]));
    modf_nxt = fault || (modf_q && !(wr_stat && bus_wdata[SB_MODF]));
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ctrl_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      wcol_q  <= 1'b0;
      modf_q  <= 1'b0;
      sck_p_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_nxt;
      busy_q  <= busy_nxt;
      done_q  <= done_nxt;
      wcol_q  <= wcol_nxt;
      modf_q  <= modf_nxt;
      sck_p_q <= sck_s;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {{PAD_C{1'b0}}, ctrl_q};
      A_STAT:  bus_rdata = {{PAD_S{1'b0}}, modf_q, wcol_q, done_q};
      A_DATA:  bus_rdata = rx;
      default: bus_rdata = '0;
    endcase
  end

  assign sck_o   = m_sck;
  assign sck_oe  = en && mstr;
  assign mosi_o  = out_bit;
  assign mosi_oe = en && mstr;
  assign miso_o  = out_bit;
  assign miso_oe = slv_act;
  assign ss_n_o  = ctrl_q[CB_SSV];
  assign ss_n_oe = en && mstr && ctrl_q[CB_SSO];
  assign irq     = gie && ctrl_q[CB_IE] && (done_q || modf_q);
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk
  import spi_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gie,
  input logic              irq,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              busy_q,
  input logic              done_q,
  input logic              wcol_q,
  input logic              modf_q,
  input logic              xfer_done,
  input logic              wr_data,
  input logic              wr_stat,
  input logic [DW-1:0]     bus_wdata,
  input logic              sck_oe,
  input logic              mosi_oe,
  input logic              miso_oe,
  input logic              ss_n_oe
);
  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && ctrl_q[CB_IE] && (done_q || modf_q)));

  // R3
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy_q) |=> wcol_q);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(wr_stat && bus_wdata[SB_DONE])) |=> done_q);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> done_q);

  // R7
  modf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf_q) |-> (!sck_oe && !mosi_oe && !ss_n_oe && !ctrl_q[CB_EN] && !ctrl_q[CB_MSTR]));

  // R7
  modf_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf_q) |=> !$rose(done_q));

  // R8
  modf_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf_q) |-> $past(!ctrl_q[CB_SSO]));

  // R10
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(miso_oe && mosi_oe));
endmodule

bind spi_ctrl spi_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .gie(gie), .irq(irq),
  .ctrl_q(ctrl_q), .busy_q(busy_q), .done_q(done_q), .wcol_q(wcol_q),
  .modf_q(modf_q), .xfer_done(xfer_done), .wr_data(wr_data),
  .wr_stat(wr_stat), .bus_wdata(bus_wdata), .sck_oe(sck_oe),
  .mosi_oe(mosi_oe), .miso_oe(miso_oe), .ss_n_oe(ss_n_oe)
);

// File: tb/sim_spi_ctrl.sv
`timescale 1ns/1ps
module sim_spi_ctrl;
  logic clk, rst_n, gie;
  logic wr0, wr1;
  logic [1:0] addr0, addr1;
  logic [7:0] wdata0, wdata1, rdata0, rdata1;
  logic irq0, irq1;
  logic u0_sck, u0_sck_oe, u0_mosi, u0_mosi_oe, u0_miso, u0_miso_oe, u0_ss, u0_ss_oe;
  logic u1_sck, u1_sck_oe, u1_mosi, u1_mosi_oe, u1_miso, u1_miso_oe, u1_ss, u1_ss_oe;
  logic ss0_in, line_sck, line_mosi, line_miso, line_ss;
  int   nchk, nerr, cyc, rises, last_rise, last_gap;
  logic sck0_d;

  assign line_sck  = u0_sck_oe ? u0_sck : 1'b0;
  assign line_mosi = u0_mosi_oe ? u0_mosi : 1'b0;
  assign line_miso = u1_miso_oe ? u1_miso : 1'b1;
  assign line_ss   = u0_ss_oe ? u0_ss : 1'b1;

  spi_ctrl #(.DW(8), .SCK_HALF(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr0), .bus_addr(addr0), .bus_wdata(wdata0),
    .bus_rdata(rdata0), .gie(gie), .irq(irq0),
    .sck_i(1'b0), .sck_o(u0_sck), .sck_oe(u0_sck_oe),
    .mosi_i(1'b0), .mosi_o(u0_mosi), .mosi_oe(u0_mosi_oe),
    .miso_i(line_miso), .miso_o(u0_miso), .miso_oe(u0_miso_oe),
    .ss_n_i(ss0_in), .ss_n_o(u0_ss), .ss_n_oe(u0_ss_oe));

  spi_ctrl #(.DW(8), .SCK_HALF(4)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr1), .bus_addr(addr1), .bus_wdata(wdata1),
    .bus_rdata(rdata1), .gie(gie), .irq(irq1),
    .sck_i(line_sck), .sck_o(u1_sck), .sck_oe(u1_sck_oe),
    .mosi_i(line_mosi), .mosi_o(u1_mosi), .mosi_oe(u1_mosi_oe),
    .miso_i(1'b1), .miso_o(u1_miso), .miso_oe(u1_miso_oe),
    .ss_n_i(line_ss), .ss_n_o(u1_ss), .ss_n_oe(u1_ss_oe));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin cyc = 0; rises = 0; last_rise = 0; last_gap = 0; end
  always @(posedge clk) begin
    cyc++;
    sck0_d <= u0_sck;
    if (u0_sck && !sck0_d) begin
      rises++;
      last_gap = cyc - last_rise;
      last_rise = cyc;
    end
    if (cyc > 100000) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  // {mlsb, slsb, master tx, slave tx, expected master rx, expected slave rx}
  localparam logic [33:0] VEC [5] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C, 8'h3C, 8'hA5},
    {1'b1, 1'b1, 8'h12, 8'h34, 8'h34, 8'h12},
    {1'b0, 1'b1, 8'h01, 8'h02, 8'h40, 8'h80},
    {1'b1, 1'b0, 8'hF0, 8'h0F, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'hFF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int unit, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    if (unit == 0) begin wr0 = 1'b1; addr0 = a; wdata0 = d; end
    else           begin wr1 = 1'b1; addr1 = a; wdata1 = d; end
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rd(input int unit, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    if (unit == 0) addr0 = a; else addr1 = a;
    #1;
    d = (unit == 0) ? rdata0 : rdata1;
  endtask

  task automatic wait_done(input int unit);
    logic [7:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(unit, 2'd1, s);
      if (s[0]) break;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int r0;
    nchk = 0; nerr = 0;
    rst_n = 1'b0; gie = 1'b1; ss0_in = 1'b1;
    wr0 = 1'b0; wr1 = 1'b0; addr0 = '0; addr1 = '0; wdata0 = '0; wdata1 = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R11 reset state
    rd(0, 2'd0, v); chk("R11 ctrl", v, 8'h00);
    rd(0, 2'd1, v); chk("R11 status", v, 8'h00);
    chk("R11 irq", {7'b0, irq0}, 8'h00);
    chk("R11 oe", {4'b0, u0_sck_oe, u0_mosi_oe, u0_miso_oe, u0_ss_oe}, 8'h00);

    // R1 R2 R5 R10 vector walk
    foreach (VEC[k]) begin
      logic [33:0] t;
      t = VEC[k];
      wr(1, 2'd0, {5'b0, t[32], 2'b01});
      wr(1, 2'd2, t[23:16]);
      wr(0, 2'd0, {3'b000, 1'b1, 1'b0, t[33], 2'b11});
      idle(4);
      chk("R10 slave drives miso when selected", {7'b0, u1_miso_oe}, 8'h01);
      r0 = rises;
      wr(0, 2'd2, t[31:24]);
      wait_done(0);
      idle(10);
      if (k == 0) begin
        chk("R2 sck pulse count", 8'(rises - r0), 8'd8);
        chk("R2 sck period", 8'(last_gap), 8'd8);
        chk("R6 irq off with enable clear", {7'b0, irq0}, 8'h00);
      end
      rd(0, 2'd1, v); chk("R5 master done flag", v, 8'h01);
      rd(0, 2'd2, v); chk("R1 master rx", v, t[15:8]);
      rd(1, 2'd1, v); chk("R10 slave done flag", v, 8'h01);
      rd(1, 2'd2, v); chk("R1 slave rx", v, t[7:0]);
      if (k == 0) begin
        wr(0, 2'd1, 8'h00);
        rd(0, 2'd1, v); chk("R9 write zero keeps flag", v, 8'h01);
        wr(0, 2'd0, 8'h3B);
        chk("R6 irq with gie and enable", {7'b0, irq0}, 8'h01);
        gie = 1'b0; #1;
        chk("R6 irq masked by gie", {7'b0, irq0}, 8'h00);
        gie = 1'b1;
      end
      wr(0, 2'd0, 8'h33);
      idle(3);
      chk("R10 slave miso released", {7'b0, u1_miso_oe}, 8'h00);
      wr(0, 2'd1, 8'h07);
      wr(1, 2'd1, 8'h07);
      rd(0, 2'd1, v); chk("R9 write one clears", v, 8'h00);
    end

    // R3 master collision, R4 slave collision
    wr(1, 2'd0, 8'h01);
    wr(1, 2'd2, 8'h96);
    wr(0, 2'd0, 8'h13);
    idle(4);
    wr(0, 2'd2, 8'h5A);
    idle(12);
    wr(0, 2'd2, 8'hFF);
    wr(1, 2'd2, 8'hEE);
    wait_done(0);
    idle(10);
    rd(0, 2'd1, v); chk("R3 master wcol and done", v, 8'h03);
    rd(0, 2'd2, v); chk("R3 master rx unchanged", v, 8'h96);
    rd(1, 2'd1, v); chk("R4 slave wcol and done", v, 8'h03);
    rd(1, 2'd2, v); chk("R3 slave got original byte", v, 8'h5A);
    wr(0, 2'd0, 8'h33);
    wr(0, 2'd1, 8'h07);
    wr(1, 2'd1, 8'h07);

    // R7 mode fault mid transfer
    wr(0, 2'd0, 8'h0B);
    wr(0, 2'd2, 8'hC3);
    idle(6);
    ss0_in = 1'b0;
    idle(6);
    rd(0, 2'd0, v); chk("R7 ctrl en/mstr cleared", v, 8'h08);
    rd(0, 2'd1, v); chk("R7 fault flag", v, 8'h04);
    chk("R7 drivers off", {5'b0, u0_sck_oe, u0_mosi_oe, u0_ss_oe}, 8'h00);
    chk("R7 irq on fault", {7'b0, irq0}, 8'h01);
    idle(60);
    rd(0, 2'd1, v); chk("R7 no done after abort", v, 8'h04);
    ss0_in = 1'b1;
    wr(0, 2'd1, 8'h04);
    rd(0, 2'd1, v); chk("R9 fault cleared", v, 8'h00);

    // R8 slave-select as output
    wr(0, 2'd0, 8'h33);
    ss0_in = 1'b0;
    idle(8);
    rd(0, 2'd1, v); chk("R8 no fault in output mode", v, 8'h00);
    rd(0, 2'd0, v); chk("R8 ctrl kept", v, 8'h33);
    chk("R8 ss out high", {6'b0, u0_ss_oe, u0_ss}, 8'h03);
    wr(0, 2'd0, 8'h13);
    chk("R8 ss out low", {6'b0, u0_ss_oe, u0_ss}, 8'h02);
    ss0_in = 1'b1;

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule